// File: doc/BRIEF.md
# Timer and Legacy Interrupt Status Controller

This block keeps the control and status bytes that sit between two external interval timers, a set of trapped legacy sound ports, and one shared interrupt line. The host reaches it over a byte-wide register bus with a 3-bit address. A write to the control byte turns each interrupt source on or off. The same write also clears any status flag that belongs to a source it has just disabled. Writes to the trapped legacy ports latch status flags and raise the shared interrupt when their source is enabled. Timer expiry is not counted here: each timer reports expiry as a one-cycle pulse on its own input. The block records that pulse in a timer-status byte that holds both maskable and non-maskable bits.

Each register address has a fixed role. Address 0 is the control byte. Address 1 is the status port: a read returns either the timer-status byte or a plain legacy status byte, and a write stores the command byte. Address 2 is the data port. A write to it either programs the timer mask byte or acts as a legacy data trap; which one depends on the command byte. Addresses 4 and 5 are the two legacy trap ports. Reads have no side effects.

Top module: `tlirq_ctrl`

## Requirements
- R1: Synchronous active-high reset. On reset every stored byte is zero: control, command, legacy status, legacy data, mask, timer status and interrupt status. The `irq` output is low.
- R2: Reads are combinational and depend on the address. Address 0 returns control. Address 2 returns legacy data. Address 3 returns command. Address 4 returns interrupt status. Address 5 returns the mask byte. Addresses 6 and 7 return 0xFF.
- R3: A read of address 1 returns the timer-status byte when control bit 0 is 1, and the legacy status byte when control bit 0 is 0.
- R4: Timer path of the data port. A write to address 2 takes this path when command equals 0x04 and control bit 0 is 0. If wdata bit 7 is 1, timer-status bits 7..5 are cleared. Otherwise the mask byte takes wdata. In both cases legacy data is left unchanged.
- R5: Trap path of the data port. Every other write to address 2 stores legacy data. If control bit 1 is 1, it also sets timer-status bit 0 and interrupt-status bit 4.
- R6: A write to address 4 sets timer-status bit 3 and interrupt-status bit 4, but only when control bit 5 is 1. A write to address 5 does the same with timer-status bit 4. When control bit 5 is 0, both writes change nothing.
- R7: A control write with bit 5 at 0 clears timer-status bits 4 and 3. A control write with bit 1 at 0 clears timer-status bit 0. After these clears, if timer-status bits 0, 3 and 4 are all 0, interrupt-status bit 4 is cleared.
- R8: A control write with bit 2 at 0 clears timer-status bit 2 and interrupt-status bit 2. A control write with bit 3 at 0 clears timer-status bit 1 and interrupt-status bit 3.
- R9: A timer-1 pulse sets timer-status bits 7 and 6 when mask bit 6 is 0. If control bit 2 is 1, the pulse also sets timer-status bit 2 and interrupt-status bit 2. The pulse is judged against the control and mask values that follow any write in the same cycle.
- R10: A timer-2 pulse sets timer-status bits 7 and 5 when mask bit 5 is 0. If control bit 3 is 1, the pulse also sets timer-status bit 1 and interrupt-status bit 3. The same same-cycle rule as R9 applies.
- R11: `irq` is registered. It equals the OR of all interrupt-status bits as they stood one clock earlier.
- R12: A write to address 1 stores the command byte. A write to address 3 stores the legacy status byte. Writes to addresses 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| t1_tick | input | 1 | Timer-1 expiry pulse |
| t2_tick | input | 1 | Timer-2 expiry pulse |
| rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions rely on three assumptions about the inputs:
- At most one register write lands in any cycle. The bus has a single address, so this always holds.
- Reset is held for at least two clocks, so the registered interrupt is clean before the first checked edge.
- Timer pulses may arrive in any cycle, including the cycle of a control write.

The bench respects these assumptions. It drives each input on the falling edge, holds reset for four clocks, and deliberately lines up a control write with a timer pulse to exercise the same-cycle ordering rule.

// File: rtl/tlirq_pkg.sv
package tlirq_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] ADR_CTRL  = 3'd0;
    localparam logic [AW-1:0] ADR_STAT  = 3'd1;
    localparam logic [AW-1:0] ADR_DATA  = 3'd2;
    localparam logic [AW-1:0] ADR_AUX   = 3'd3;
    localparam logic [AW-1:0] ADR_TRAPA = 3'd4;
    localparam logic [AW-1:0] ADR_TRAPB = 3'd5;

    localparam logic [DW-1:0] CMD_TIMER = 8'h04;
    localparam logic [DW-1:0] RD_NONE   = 8'hFF;

    // control bits
    localparam int CTL_SEL     = 0;
    localparam int CTL_DATA_EN = 1;
    localparam int CTL_T1_EN   = 2;
    localparam int CTL_T2_EN   = 3;
    localparam int CTL_TRAP_EN = 5;
    // timer status bits
    localparam int TS_DATA  = 0;
    localparam int TS_T2    = 1;
    localparam int TS_T1    = 2;
    localparam int TS_TRAPA = 3;
    localparam int TS_TRAPB = 4;
    localparam int TS_M2    = 5;
    localparam int TS_M1    = 6;
    localparam int TS_MANY  = 7;
    // interrupt status bits
    localparam int IS_T1  = 2;
    localparam int IS_T2  = 3;
    localparam int IS_LEG = 4;
    // mask bits
    localparam int MSK_T2 = 5;
    localparam int MSK_T1 = 6;

    typedef struct packed {
        logic ctrl;
        logic cmd;
        logic data;
        logic aux;
        logic trapa;
        logic trapb;
    } wr_strobe_t;

    typedef struct packed {
        logic [DW-1:0] ctl;
        logic [DW-1:0] cmd;
        logic [DW-1:0] lstat;
        logic [DW-1:0] ldata;
        logic [DW-1:0] mask;
        logic [DW-1:0] tstat;
        logic [DW-1:0] istat;
    } regs_t;

    function automatic logic [DW-1:0] with_bit(logic [DW-1:0] v, int idx, logic b);
        logic [DW-1:0] r;
        r = v;
        r[idx] = b;
        return r;
    endfunction
endpackage

// File: rtl/tlirq_decode.sv
module tlirq_decode
    import tlirq_pkg::*;
(
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output wr_strobe_t    stb
);
    always_comb begin
        stb       = '0;
        stb.ctrl  = wr_en && (addr == ADR_CTRL);
        stb.cmd   = wr_en && (addr == ADR_STAT);
        stb.data  = wr_en && (addr == ADR_DATA);
        stb.aux   = wr_en && (addr == ADR_AUX);
        stb.trapa = wr_en && (addr == ADR_TRAPA);
        stb.trapb = wr_en && (addr == ADR_TRAPB);
    end
endmodule

// File: rtl/tlirq_core.sv
module tlirq_core
    import tlirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wr_strobe_t    stb,
    input  logic [DW-1:0] wdata,
    input  logic          t1_tick,
    input  logic          t2_tick,
    output regs_t         regs,
    output logic          irq
);
    regs_t nxt;

    always_comb begin
        nxt = regs;
        if (stb.ctrl) begin
            nxt.ctl = wdata;
            if (!wdata[CTL_TRAP_EN]) begin
                nxt.tstat[TS_TRAPA] = 1'b0;
                nxt.tstat[TS_TRAPB] = 1'b0;
            end
            if (!wdata[CTL_DATA_EN])
                nxt.tstat[TS_DATA] = 1'b0;
            if (!(nxt.tstat[TS_DATA] | nxt.tstat[TS_TRAPA] | nxt.tstat[TS_TRAPB]))
                nxt.istat[IS_LEG] = 1'b0;
            if (!wdata[CTL_T1_EN]) begin
                nxt.tstat[TS_T1] = 1'b0;
                nxt.istat[IS_T1] = 1'b0;
            end
            if (!wdata[CTL_T2_EN]) begin
                nxt.tstat[TS_T2] = 1'b0;
                nxt.istat[IS_T2] = 1'b0;
            end
        end
        if (stb.cmd)
            nxt.cmd = wdata;
        if (stb.aux)
            nxt.lstat = wdata;
        if (stb.data) begin
            if ((regs.cmd == CMD_TIMER) && !regs.ctl[CTL_SEL]) begin
                if (wdata[DW-1])
                    nxt.tstat = {3'b000, regs.tstat[4:0]};
                else
                    nxt.mask = wdata;
            end else begin
                nxt.ldata = wdata;
                if (regs.ctl[CTL_DATA_EN]) begin
                    nxt.tstat = with_bit(nxt.tstat, TS_DATA, 1'b1);
                    nxt.istat = with_bit(nxt.istat, IS_LEG, 1'b1);
                end
            end
        end
        if (stb.trapa && regs.ctl[CTL_TRAP_EN]) begin
            nxt.tstat = with_bit(nxt.tstat, TS_TRAPA, 1'b1);
            nxt.istat = with_bit(nxt.istat, IS_LEG, 1'b1);
        end
        if (stb.trapb && regs.ctl[CTL_TRAP_EN]) begin
            nxt.tstat = with_bit(nxt.tstat, TS_TRAPB, 1'b1);
            nxt.istat = with_bit(nxt.istat, IS_LEG, 1'b1);
        end
        if (t1_tick) begin
            if (!nxt.mask[MSK_T1]) begin
                nxt.tstat[TS_MANY] = 1'b1;
                nxt.tstat[TS_M1]   = 1'b1;
            end
            if (nxt.ctl[CTL_T1_EN]) begin
                nxt.tstat[TS_T1] = 1'b1;
                nxt.istat[IS_T1] = 1'b1;
            end
        end
        if (t2_tick) begin
            if (!nxt.mask[MSK_T2]) begin
                nxt.tstat[TS_MANY] = 1'b1;
                nxt.tstat[TS_M2]   = 1'b1;
            end
            if (nxt.ctl[CTL_T2_EN]) begin
                nxt.tstat[TS_T2] = 1'b1;
                nxt.istat[IS_T2] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
            irq  <= 1'b0;
        end else begin
            regs <= nxt;
            irq  <= |regs.istat;
        end
    end
endmodule

// File: rtl/tlirq_rdmux.sv
module tlirq_rdmux
    import tlirq_pkg::*;
(
    input  regs_t         regs,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata
);
    always_comb begin
        case (addr)
            ADR_CTRL:  rdata = regs.ctl;
            ADR_STAT:  rdata = regs.ctl[CTL_SEL] ? regs.tstat : regs.lstat;
            ADR_DATA:  rdata = regs.ldata;
            ADR_AUX:   rdata = regs.cmd;
            ADR_TRAPA: rdata = regs.istat;
            ADR_TRAPB: rdata = regs.mask;
            default:   rdata = RD_NONE;
        endcase
    end
endmodule

// File: rtl/tlirq_ctrl.sv
module tlirq_ctrl
    import tlirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          t1_tick,
    input  logic          t2_tick,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    wr_strobe_t stb;
    regs_t      regs;

    tlirq_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .stb   (stb)
    );

    tlirq_core u_core (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .wdata   (wdata),
        .t1_tick (t1_tick),
        .t2_tick (t2_tick),
        .regs    (regs),
        .irq     (irq)
    );

    tlirq_rdmux u_rd (
        .regs  (regs),
        .addr  (addr),
        .rdata (rdata)
    );
endmodule

// File: rtl/tlirq_ctrl_chk.sv
module tlirq_ctrl_chk
    import tlirq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic          wd_trap,
    input logic          wd_t1,
    input logic          t1_tick,
    input logic          ctl_trap,
    input logic          ctl_data,
    input logic          ctl_t1,
    input logic          ts_trapb,
    input logic          ts_trapa,
    input logic          ts_t1,
    input logic          ts_data,
    input logic          is_leg,
    input logic          is_t1,
    input logic          is_any,
    input logic          irq
);
    // R11
    irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en || !wr_en) |=> (irq == $past(is_any)));

    // R7
    trap_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_CTRL && !wd_trap) |=> (!ts_trapa && !ts_trapb));

    // R8
    t1_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_CTRL && !wd_t1) |=> (!ts_t1 && !is_t1));

    // R9
    t1_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_t1 |-> (!is_t1 && !ts_t1));

    // R5
    data_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_data |-> !ts_data);

    // R9
    t1_set_chk: assert property (@(posedge clk) disable iff (rst)
        (t1_tick && ctl_t1 && !(wr_en && addr == ADR_CTRL)) |=> (ts_t1 && is_t1));

    // R6
    trapa_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_TRAPA && ctl_trap) |=> (ts_trapa && is_leg));
endmodule

bind tlirq_ctrl tlirq_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wd_trap  (wdata[5]),
    .wd_t1    (wdata[2]),
    .t1_tick  (t1_tick),
    .ctl_trap (regs.ctl[5]),
    .ctl_data (regs.ctl[1]),
    .ctl_t1   (regs.ctl[2]),
    .ts_trapb (regs.tstat[4]),
    .ts_trapa (regs.tstat[3]),
    .ts_t1    (regs.tstat[2]),
    .ts_data  (regs.tstat[0]),
    .is_leg   (regs.istat[4]),
    .is_t1    (regs.istat[2]),
    .is_any   (|regs.istat),
    .irq      (irq)
);

// File: tb/tlirq_ctrl_tb.sv
`timescale 1ns/1ps
module tlirq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       t1_tick = 1'b0;
    logic       t2_tick = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    int m_ctl = 0, m_cmd = 0, m_lst = 0, m_ldat = 0, m_msk = 0, m_ts = 0, m_is = 0;
    bit m_irq = 0;

    always #4 clk = ~clk;

    tlirq_ctrl u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr), .wdata (wdata),
        .t1_tick (t1_tick), .t2_tick (t2_tick), .rdata (rdata), .irq (irq)
    );

    function automatic int model_read(int a);
        case (a)
            0: return m_ctl;
            1: return ((m_ctl & 1) != 0) ? m_ts : m_lst;
            2: return m_ldat;
            3: return m_cmd;
            4: return m_is;
            5: return m_msk;
            default: return 255;
        endcase
    endfunction

    task automatic model_step(bit we, int a, int d, bit e1, bit e2);
        m_irq = (m_is != 0);
        if (we) begin
            if (a == 0) begin
                m_ctl = d;
                if ((d & 32) == 0) m_ts = m_ts & ~24;
                if ((d & 2) == 0)  m_ts = m_ts & ~1;
                if ((m_ts & 25) == 0) m_is = m_is & ~16;
                if ((d & 4) == 0) begin m_ts = m_ts & ~4; m_is = m_is & ~4; end
                if ((d & 8) == 0) begin m_ts = m_ts & ~2; m_is = m_is & ~8; end
            end else if (a == 1) m_cmd = d;
            else if (a == 2) begin
                if (m_cmd == 4 && (m_ctl & 1) == 0) begin
                    if ((d & 128) != 0) m_ts = m_ts & 31;
                    else m_msk = d;
                end else begin
                    m_ldat = d;
                    if ((m_ctl & 2) != 0) begin m_ts = m_ts | 1; m_is = m_is | 16; end
                end
            end else if (a == 3) m_lst = d;
            else if (a == 4 && (m_ctl & 32) != 0) begin m_ts = m_ts | 8; m_is = m_is | 16; end
            else if (a == 5 && (m_ctl & 32) != 0) begin m_ts = m_ts | 16; m_is = m_is | 16; end
        end
        if (e1) begin
            if ((m_msk & 64) == 0) m_ts = m_ts | 192;
            if ((m_ctl & 4) != 0) begin m_ts = m_ts | 4; m_is = m_is | 4; end
        end
        if (e2) begin
            if ((m_msk & 32) == 0) m_ts = m_ts | 160;
            if ((m_ctl & 8) != 0) begin m_ts = m_ts | 2; m_is = m_is | 8; end
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // one clock: drive at falling edge, compare read data and irq before the rising edge
    task automatic step(bit we, int a, int d, bit e1, bit e2, string req);
        @(negedge clk);
        wr_en = we; addr = a[2:0]; wdata = d[7:0]; t1_tick = e1; t2_tick = e2;
        #1;
        check(req, $sformatf("rdata@%0d", a), int'(rdata), model_read(a));
        check("R11", "irq", int'(irq), int'(m_irq));
        @(posedge clk);
        model_step(we, a, d, e1, e2);
    endtask

    task automatic rd(int a, string req);
        step(0, a, 0, 0, 0, req);
    endtask

    task automatic wr(int a, int d, string req);
        step(1, a, d, 0, 0, req);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", "irq in reset", int'(irq), 0);
        check("R1", "ctl in reset", int'(rdata), 0);
        rst = 1'b0;
        // R1 reset values, R2 address map
        for (int a = 0; a < 8; a++) rd(a, (a < 6) ? "R1" : "R2");
        // R12 command and legacy status writes
        wr(1, 4, "R12");
        rd(3, "R2");
        wr(3, 8'h5A, "R12");
        rd(1, "R3");
        wr(6, 8'hAA, "R12");
        wr(7, 8'h55, "R12");
        for (int a = 0; a < 8; a++) rd(a, "R12");
        // R4 timer path: mask write, legacy data untouched
        wr(2, 8'h23, "R4");
        rd(5, "R4");
        rd(2, "R4");
        // enable traps, data trap, both timers
        wr(0, 8'h2E, "R7");
        step(0, 4, 0, 1, 0, "R9");
        step(0, 4, 0, 0, 1, "R10");
        rd(4, "R9");
        wr(0, 8'h2F, "R3");
        rd(1, "R3");
        rd(1, "R11");
        // R4 clear of maskable bits (needs control bit 0 low)
        wr(0, 8'h2E, "R4");
        wr(2, 8'h80, "R4");
        wr(0, 8'h2F, "R4");
        rd(1, "R4");
        // R6 traps while enabled
        wr(4, 0, "R6");
        wr(5, 0, "R6");
        rd(1, "R6");
        rd(4, "R6");
        // R7 disable traps and data trap
        wr(0, 8'h0D, "R7");
        rd(1, "R7");
        rd(4, "R7");
        // R8 disable both timers
        wr(0, 8'h01, "R8");
        rd(1, "R8");
        rd(4, "R8");
        rd(4, "R11");
        // R6 traps ignored when disabled
        wr(4, 0, "R6");
        wr(5, 0, "R6");
        rd(1, "R6");
        rd(4, "R6");
        // R5 data trap path
        wr(0, 8'h03, "R5");
        wr(2, 8'h77, "R5");
        rd(2, "R5");
        rd(1, "R5");
        rd(4, "R5");
        wr(0, 8'h21, "R7");
        rd(1, "R7");
        rd(4, "R7");
        // R9/R10 with nonmaskable disabled
        wr(0, 8'h20, "R4");
        wr(2, 8'h40, "R4");
        step(0, 5, 0, 0, 1, "R10");
        step(0, 5, 0, 1, 0, "R9");
        wr(0, 8'h21, "R9");
        rd(1, "R10");
        // R9 same-cycle control write and timer-1 pulse
        step(1, 0, 8'h05, 1, 0, "R9");
        rd(1, "R9");
        rd(4, "R9");
        rd(4, "R11");
        // mixed traffic
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 300; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0], int'(lf[3:1]), int'(lf[11:4]), lf[12] & lf[13], lf[14] & lf[15], "R11");
            end
        end
        for (int a = 0; a < 8; a++) rd(a, "R2");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule